// File: doc/BRIEF.md
# Program Status Word Generator

This block forms the status word that a non-volatile memory places on its data bus whenever the bus is read while a program operation is in progress, or while a failed program operation is still waiting for a reset command. During that time a read at any address returns this word instead of array data. The word reports progress and failure: a polling bit that carries the inverse of the bit being written, a bit that flips on each read, sticky failure flags for bad data and for loss of the high programming voltage, and a ready indication for the multi-word programming controller.

The program controllers drive the inputs. They give a pulse when a new program operation begins, a level while it is busy, the data bit being written, single-cycle failure events, the multi-word activity and ready levels, and a strobe for each completed bus read. The command decoder sends a clear request when the reset command arrives. The word is built combinationally from the held state and the live inputs, so a read in a given cycle sees it without delay. The strobe then advances the flip bit at the end of that cycle.

Top module: `prog_status_gen`

## Requirements
- R1: `stat_show` is 1 exactly when `pgm_busy` is 1 or the failure flag is held; while `stat_show` is 0, every bit of `status_word` is 0.
- R2: While `stat_show` is 1, bit 7 of `status_word` is the inverse of `tgt_bit7` in the same cycle.
- R3: Bit 6 of `status_word` shows the flip bit. The flip bit inverts at a clock edge where `rd_strobe` is 1 and `stat_show` is 1, and holds at every other edge. A `pgm_start` pulse clears it to 0 and wins over a strobe in the same cycle.
- R4: Bit 5 of `status_word` is the failure flag. It is set at an edge where `fail_evt` or `vhv_lost_evt` is 1, it holds until an edge with `clr_req`, and a set wins over a clear in the same cycle.
- R5: Bit 4 of `status_word` is the voltage flag. It is set only by `vhv_lost_evt`, it is cleared by `clr_req` (a set wins over a clear), and it is never 1 while the failure flag is 0.
- R6: While `stat_show` is 1, bit 0 of `status_word` is 1 when `mw_active` is 1 and `mw_ready` is 0, and 0 otherwise.
- R7: Bits 3 to 1 and bits above 7 of `status_word` are always 0.
- R8: After a synchronous active-low reset, both flags and the flip bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_start | input | 1 | Pulse: a new program operation begins |
| pgm_busy | input | 1 | Program controller is running |
| tgt_bit7 | input | 1 | Bit 7 of the word being programmed |
| fail_evt | input | 1 | Pulse: data failed to program |
| vhv_lost_evt | input | 1 | Pulse: high programming voltage dropped |
| clr_req | input | 1 | Pulse: reset command clears the flags |
| mw_active | input | 1 | Multi-word programming in progress |
| mw_ready | input | 1 | Multi-word controller ready for next word |
| rd_strobe | input | 1 | Pulse: a bus read completes this cycle |
| stat_show | output | 1 | Status word replaces array data |
| status_word | output | DATA_W | Status word, upper byte driven 0 |

## Verification
Two pairs of functions can collide in one cycle. A clear request can meet a failure event, and a start pulse can meet a read strobe. The bench forces both collisions with directed cycles, then lets the random phase produce them again at low rates. It checks that the flags stay set after a clear that meets a failure event, and that the flip bit reads 0 after a start that meets a strobe. The expected result in every cycle comes from a bench model that applies the same set-before-clear and start-before-strobe rules to its own copy of the state.

// File: rtl/psg_pkg.sv
// Shared definitions for the program status word generator.
// Assumes the status byte sits in the low eight bits of the data bus.
package psg_pkg;

    localparam int STAT_W = 8;

    // Field layout of the status byte, most significant bit first.
    typedef struct packed {
        logic       poll;     // inverse of bit 7 of the data being written
        logic       flip;     // inverts on every status read
        logic       fail;     // sticky failure flag
        logic       vlost;    // sticky high-voltage loss flag
        logic [2:0] rsvd;     // always zero
        logic       mw_busy;  // multi-word controller busy with a word
    } stat_byte_t;

endpackage

// File: rtl/psg_flags.sv
// Sticky failure flags.
// The failure flag is set by either failure event. The voltage flag is set
// only by voltage loss. Both clear on a clear request. A set wins over a
// clear that arrives in the same cycle, so no failure report is lost.
module psg_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    input  logic vhv_lost_evt,
    input  logic clr_req,
    output logic fail_q,
    output logic vlost_q
);

    logic any_fail;

    // Either kind of failure marks the operation as failed.
    always_comb begin
        any_fail = fail_evt | vhv_lost_evt;
    end

    // Failure flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (any_fail) begin
            fail_q <= 1'b1;
        end else if (clr_req) begin
            fail_q <= 1'b0;
        end
    end

    // Voltage flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vlost_q <= 1'b0;
        end else if (vhv_lost_evt) begin
            vlost_q <= 1'b1;
        end else if (clr_req) begin
            vlost_q <= 1'b0;
        end
    end

    assert_vlost_needs_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vlost_q |-> fail_q);

    assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr_req) |=> fail_q);

    assert_fail_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !fail_evt && !vhv_lost_evt) |=> !fail_q);

endmodule

// File: rtl/psg_toggle.sv
// Flip bit that inverts once per completed status read.
// Assumes rd_strobe pulses once per bus read. A read that returns array data
// (show low) leaves the bit alone. A start pulse returns it to 0 and wins
// over a strobe in the same cycle.
module psg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_start,
    input  logic rd_strobe,
    input  logic show,
    output logic flip_q
);

    logic adv;

    // A status read is complete when the strobe comes while status is shown.
    always_comb begin
        adv = rd_strobe & show;
    end

    // Flip register: start clears, a status read inverts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_q <= 1'b0;
        end else if (pgm_start) begin
            flip_q <= 1'b0;
        end else if (adv) begin
            flip_q <= ~flip_q;
        end
    end

    assert_flip_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !flip_q);

    assert_flip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_start && !(rd_strobe && show)) |=> $stable(flip_q));

    assert_flip_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_start && rd_strobe && show) |=> (flip_q != $past(flip_q)));

endmodule

// File: rtl/psg_pack.sv
// Builds the data-bus word from the held state and the live inputs.
// Assumes DATA_W is at least the status byte width. Bits above the byte are
// don't-care on the bus and are driven 0. The whole word is 0 when not shown.
module psg_pack
    import psg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              show,
    input  logic              tgt_bit7,
    input  logic              flip_q,
    input  logic              fail_q,
    input  logic              vlost_q,
    input  logic              mw_active,
    input  logic              mw_ready,
    output logic [DATA_W-1:0] word
);

    localparam int HI_W = DATA_W - STAT_W;

    stat_byte_t sb;

    // Assemble the status byte fields.
    always_comb begin
        sb.poll    = ~tgt_bit7;
        sb.flip    = flip_q;
        sb.fail    = fail_q;
        sb.vlost   = vlost_q;
        sb.rsvd    = 3'b000;
        sb.mw_busy = mw_active & ~mw_ready;
    end

    generate
        if (HI_W > 0) begin : g_wide
            // Widen the byte with a zero upper part; blank when not shown.
            always_comb begin
                word = show ? {{HI_W{1'b0}}, sb} : '0;
            end
        end else begin : g_byte
            // Bus is exactly one byte wide; blank when not shown.
            always_comb begin
                word = show ? sb : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/prog_status_gen.sv
// Program status word generator: top level.
// Joins the sticky flags, the flip bit and the word assembly. Status replaces
// array data while the controller is busy or a failure is still held. The
// command decoder clears failures with a clear request.
module prog_status_gen #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_start,
    input  logic              pgm_busy,
    input  logic              tgt_bit7,
    input  logic              fail_evt,
    input  logic              vhv_lost_evt,
    input  logic              clr_req,
    input  logic              mw_active,
    input  logic              mw_ready,
    input  logic              rd_strobe,
    output logic              stat_show,
    output logic [DATA_W-1:0] status_word
);

    logic fail_q;
    logic vlost_q;
    logic flip_q;

    // Status is visible while running or while a failure awaits a clear.
    always_comb begin
        stat_show = pgm_busy | fail_q;
    end

    psg_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_evt     (fail_evt),
        .vhv_lost_evt (vhv_lost_evt),
        .clr_req      (clr_req),
        .fail_q       (fail_q),
        .vlost_q      (vlost_q)
    );

    psg_toggle u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_start (pgm_start),
        .rd_strobe (rd_strobe),
        .show      (stat_show),
        .flip_q    (flip_q)
    );

    psg_pack #(.DATA_W(DATA_W)) u_pack (
        .show      (stat_show),
        .tgt_bit7  (tgt_bit7),
        .flip_q    (flip_q),
        .fail_q    (fail_q),
        .vlost_q   (vlost_q),
        .mw_active (mw_active),
        .mw_ready  (mw_ready),
        .word      (status_word)
    );

    assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_show |-> (status_word == '0));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[3:1] == 3'b000);

    assert_poll_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_show |-> (status_word[7] != tgt_bit7));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (status_word[6:4] == 3'b000));

endmodule

// File: tb/sim_prog_status_gen.sv
`timescale 1ns/100ps
module sim_prog_status_gen;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pgm_start, pgm_busy, tgt_bit7, fail_evt, vhv_lost_evt;
    logic          clr_req, mw_active, mw_ready, rd_strobe;
    logic          stat_show;
    logic [DW-1:0] status_word;

    int n_run  = 0;
    int n_fail = 0;
    bit m_fail, m_vlost, m_flip;

    always #2.5 clk = ~clk;

    prog_status_gen #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pgm_start(pgm_start), .pgm_busy(pgm_busy),
        .tgt_bit7(tgt_bit7), .fail_evt(fail_evt), .vhv_lost_evt(vhv_lost_evt),
        .clr_req(clr_req), .mw_active(mw_active), .mw_ready(mw_ready),
        .rd_strobe(rd_strobe), .stat_show(stat_show), .status_word(status_word)
    );

    function automatic logic [DW-1:0] exp_word(bit show, bit tgt, bit fl, bit fa,
                                               bit vl, bit mwa, bit mwr);
        if (!show) return '0;
        return {8'h00, ~tgt, fl, fa, vl, 3'b000, mwa & ~mwr};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every field of the live outputs with the bench model.
    task automatic check_all();
        bit            show;
        logic [DW-1:0] e;
        show = pgm_busy | m_fail;
        e = exp_word(show, tgt_bit7, m_flip, m_fail, m_vlost, mw_active, mw_ready);
        chk("R1 show", {15'd0, stat_show}, {15'd0, show});
        chk("R1 blank", show ? '0 : status_word, '0);
        chk("R2 poll", {15'd0, status_word[7]}, {15'd0, e[7]});
        chk("R3 flip", {15'd0, status_word[6]}, {15'd0, e[6]});
        chk("R4 fail", {15'd0, status_word[5]}, {15'd0, e[5]});
        chk("R5 vlost", {15'd0, status_word[4]}, {15'd0, e[4]});
        chk("R6 mw", {15'd0, status_word[0]}, {15'd0, e[0]});
        chk("R7 zero", {status_word[15:8], 5'd0, status_word[3:1]}, '0);
    endtask

    // Advance the model through one clock edge with the current inputs.
    task automatic model_edge();
        bit show;
        show = pgm_busy | m_fail;
        if (!rst_n) begin
            m_fail = 0; m_vlost = 0; m_flip = 0;
        end else begin
            if (pgm_start) m_flip = 0;
            else if (rd_strobe && show) m_flip = ~m_flip;
            if (fail_evt || vhv_lost_evt) m_fail = 1;
            else if (clr_req) m_fail = 0;
            if (vhv_lost_evt) m_vlost = 1;
            else if (clr_req) m_vlost = 0;
        end
    endtask

    // One cycle: check outputs mid-cycle, then step model and design together.
    task automatic cyc();
        #1;
        if (rst_n) check_all();
        @(posedge clk);
        model_edge();
        #1;
        pgm_start = 0; fail_evt = 0; vhv_lost_evt = 0; clr_req = 0; rd_strobe = 0;
    endtask

    initial begin
        int cnt = 0;
        while (cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit seedv;
        seedv = 0;
        void'($urandom(32'h5A17));
        rst_n = 0; pgm_start = 0; pgm_busy = 0; tgt_bit7 = 0; fail_evt = 0;
        vhv_lost_evt = 0; clr_req = 0; mw_active = 0; mw_ready = 0; rd_strobe = 0;
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1;
        // R8: reset state, shown once busy
        pgm_busy = 1; tgt_bit7 = 1; #1;
        chk("R8 reset state", status_word, 16'h0000);
        pgm_busy = 0;
        // R3 word program: start, then reads 0,1,0
        pgm_start = 1; pgm_busy = 1; tgt_bit7 = 0; cyc();
        chk("R2 poll of zero bit", {15'd0, status_word[7]}, 16'd1);
        for (int i = 0; i < 3; i++) begin
            #1; chk("R3 flip seq", {15'd0, status_word[6]}, {15'd0, 1'(i % 2)});
            rd_strobe = 1; cyc();
        end
        // R3 completion: strobes while not shown do not move the bit
        pgm_busy = 0;
        rd_strobe = 1; cyc(); rd_strobe = 1; cyc();
        pgm_busy = 1; #1;
        chk("R3 frozen after done", {15'd0, status_word[6]}, 16'd1);
        // R3 start collides with strobe: start wins
        pgm_start = 1; rd_strobe = 1; cyc();
        chk("R3 start beats strobe", {15'd0, status_word[6]}, 16'd0);
        // R4 failure keeps status shown and flip running after busy drops
        fail_evt = 1; cyc(); pgm_busy = 0; #1;
        chk("R4 fail held", {15'd0, stat_show}, 16'd1);
        rd_strobe = 1; cyc();
        chk("R3 flips in error", {15'd0, status_word[6]}, 16'd1);
        // R4 clear meets failure: set wins
        clr_req = 1; fail_evt = 1; cyc();
        chk("R4 set beats clear", {15'd0, status_word[5]}, 16'd1);
        clr_req = 1; cyc();
        chk("R4 cleared", {15'd0, stat_show}, 16'd0);
        // R5 voltage loss sets both flags
        pgm_busy = 1; vhv_lost_evt = 1; cyc();
        chk("R5 both flags", {14'd0, status_word[5:4]}, 16'd3);
        clr_req = 1; cyc();
        chk("R5 cleared", {14'd0, status_word[5:4]}, 16'd0);
        // R6 multi-word ready
        mw_active = 1; mw_ready = 0; #1;
        chk("R6 busy word", {15'd0, status_word[0]}, 16'd1);
        mw_ready = 1; #1;
        chk("R6 ready", {15'd0, status_word[0]}, 16'd0);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(15) == 0) pgm_busy = ~pgm_busy;
            pgm_start    = ($urandom_range(31) == 0);
            tgt_bit7     = 1'($urandom_range(1));
            fail_evt     = ($urandom_range(63) == 0);
            vhv_lost_evt = ($urandom_range(127) == 0);
            clr_req      = ($urandom_range(23) == 0);
            if ($urandom_range(7) == 0) mw_active = ~mw_active;
            mw_ready     = 1'($urandom_range(1));
            rd_strobe    = 1'($urandom_range(1));
            cyc();
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule